// File: doc/BRIEF.md
# Pipelined Switchable Multiply-Add

This block computes a 16-bit multiply-add result of the form z = c ± (a + ci) · b. The two 8-bit multiplier operands, the 16-bit addend and all three controls arrive together on one cycle and are registered together. The controls are a run-time two's-complement switch, a product-negate bit and a single increment bit. The result appears on the output register a fixed number of cycles later. A new operand set can be presented every cycle, and each result uses only the controls that came with its own operands.

Internally the arithmetic is a single combinational expression between an input register chain and an output register. There is one datapath for both modes. Each 8-bit operand is widened by one bit, and that bit is the operand's top bit gated by the switch. This gives one signed 9-bit datapath that serves both the unsigned and the signed case. To subtract the product, the block negates the incremented multiplicand before the multiply. It does not negate the product. The incremented and negated multiplicand keeps enough bits to hold +256 and −(−128) exactly. The result is the low 16 bits of the exact value.

Top module: `muladd_pipe`

## Requirements
- R1: With `in_tc`=0 and `in_neg`=0, `out_z` equals ((a + ci) · b + c) mod 2^16. All three operands are read as unsigned numbers.
- R2: With `in_tc`=1, a and b are read as 8-bit two's-complement values (bit 7 is the sign) and c as a 16-bit two's-complement value. The result is the same formula taken mod 2^16.
- R3: With `in_neg`=1, `out_z` equals (c − (a + ci) · b) mod 2^16. This holds in both modes.
- R4: The increment is added at full width before the multiply. For example, a=0xFF, ci=1, tc=0 multiplies by 256, not by 0.
- R5: The result for an operand set presented at the clock edge with `in_valid`=1 appears on `out_z` with `out_valid`=1 exactly 4 rising edges later. Operand sets are accepted on every consecutive cycle.
- R6: The controls (`in_tc`, `in_neg`, `in_ci`) are pipelined with their operands. When the controls change on every cycle, each result still follows the controls that were sampled with its own operands.
- R7: `rst` (synchronous, active high) clears every stage's valid flag. Results that were in flight are dropped, and `out_valid` stays 0 until a new operand set has passed through all 4 stages.
- R8: In signed mode with negate, a=0x80 and ci=0 gives the multiplicand +128. For example, b=2, c=0 yields 0x0100.
- R9: After reset with `in_valid` held at 0, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand set present this cycle |
| in_a | input | 8 | Multiplicand |
| in_b | input | 8 | Multiplier |
| in_c | input | 16 | Addend |
| in_tc | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| in_neg | input | 1 | 1 = subtract the product from the addend |
| in_ci | input | 1 | Increment added to the multiplicand |
| out_valid | output | 1 | `out_z` holds a result |
| out_z | output | 16 | Result, low 16 bits |

## Verification
A control bit that lags or leads its operands by one stage only shows when the controls change between neighbouring samples. The bench therefore toggles mode, negate and increment on every cycle, so such a slip shows as a wrong value on the very first affected result. A bad extension bit or a truncated increment corrupts the corner operands 0x7F, 0x80 and 0xFF, and the error reaches `out_z` four cycles after the operand set enters. A stuck or missing valid stage appears as a result at the wrong cycle, an extra result, or a missing result. The scoreboard compares every result against the cycle in which its operands were issued.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

   // controls that travel with each operand set
   typedef struct packed {
      logic tc;    // two's-complement interpretation
      logic neg;   // subtract the product
      logic inc;   // increment added to the multiplicand
   } muladd_ctrl_t;

   localparam int CTRL_W = $bits(muladd_ctrl_t);

   function automatic int imax(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/muladd_reg.sv
module muladd_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vld_i,
   input  logic [W-1:0] d_i,
   output logic         vld_q,
   output logic [W-1:0] d_q
);

   if (W < 1) begin : g_bad_w
      $error("muladd_reg: W must be at least 1");
   end

   // valid flag: synchronous reset
   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_i;
   end

   // data: no reset, loads every cycle
   always_ff @(posedge clk) begin
      d_q <= d_i;
   end

   AST_VLD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> vld_q);   // R5
   AST_VLD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> !vld_q); // R7

endmodule

// File: rtl/muladd_core.sv
module muladd_core
   import muladd_pkg::*;
#(
   parameter int OPW  = 8,
   parameter int ACCW = 16
) (
   input  logic            live,   // only qualifies the checks below
   input  muladd_ctrl_t    ctrl,
   input  logic [OPW-1:0]  a,
   input  logic [OPW-1:0]  b,
   input  logic [ACCW-1:0] c,
   output logic [ACCW-1:0] z
);

   localparam int XW  = OPW + 1;                       // extended operand
   localparam int AIW = OPW + 2;                       // after increment
   localparam int ANW = OPW + 3;                       // after negation
   localparam int CXW = ACCW + 1;                      // extended addend
   localparam int FW  = imax(ANW + XW, CXW) + 1;       // full expression

   logic signed [XW-1:0]  a_x, b_x;
   logic signed [CXW-1:0] c_x;
   logic signed [AIW-1:0] a_inc;
   logic signed [ANW-1:0] a_op;
   logic signed [FW-1:0]  full;

   always_comb begin
      // selective extension: one signed datapath for both modes
      a_x   = $signed({ctrl.tc & a[OPW-1], a});
      b_x   = $signed({ctrl.tc & b[OPW-1], b});
      c_x   = $signed({ctrl.tc & c[ACCW-1], c});
      // increment kept at full width
      a_inc = AIW'(a_x) + AIW'($signed({1'b0, ctrl.inc}));
      // negate the multiplicand rather than the product
      a_op  = ctrl.neg ? -ANW'(a_inc) : ANW'(a_inc);
      // one multiply-add expression, every operand signed
      full  = FW'(a_op) * FW'(b_x) + FW'(c_x);
      z     = full[ACCW-1:0];
   end

   always_comb begin
      if (live && !ctrl.tc && !ctrl.neg)
         AST_UNS_MCAND_NONNEG: assert (a_op >= 0);  // R1
      if (live && !ctrl.tc && ctrl.neg)
         AST_NEG_MCAND_NONPOS: assert (a_op <= 0);  // R3
      if (live && !ctrl.tc && !ctrl.neg && ctrl.inc && (&a))
         AST_INC_NO_WRAP: assert (a_op == ANW'(2 ** OPW)); // R4
   end

endmodule

// File: rtl/muladd_pipe.sv
module muladd_pipe
   import muladd_pkg::*;
#(
   parameter int OPW         = 8,
   parameter int ACCW        = 16,
   parameter int OPND_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [OPW-1:0]  in_a,
   input  logic [OPW-1:0]  in_b,
   input  logic [ACCW-1:0] in_c,
   input  logic            in_tc,
   input  logic            in_neg,
   input  logic            in_ci,
   output logic            out_valid,
   output logic [ACCW-1:0] out_z
);

   localparam int NIN  = 1 + OPND_STAGES;          // input + operand stages
   localparam int PKW  = CTRL_W + ACCW + 2 * OPW;  // packed stage word
   localparam int A_LO = 0;
   localparam int B_LO = OPW;
   localparam int C_LO = 2 * OPW;
   localparam int K_LO = 2 * OPW + ACCW;

   if (OPW < 2) begin : g_bad_opw
      $error("muladd_pipe: OPW must be at least 2");
   end
   if (ACCW < OPW) begin : g_bad_accw
      $error("muladd_pipe: ACCW must not be narrower than OPW");
   end
   if (OPND_STAGES < 0) begin : g_bad_stages
      $error("muladd_pipe: OPND_STAGES must not be negative");
   end

   muladd_ctrl_t in_ctrl;
   assign in_ctrl = '{tc: in_tc, neg: in_neg, inc: in_ci};

   logic [PKW-1:0] stg_d [NIN+1];
   logic           stg_v [NIN+1];

   assign stg_d[0] = {in_ctrl, in_c, in_b, in_a};
   assign stg_v[0] = in_valid;

   for (genvar i = 0; i < NIN; i++) begin : g_stage
      muladd_reg #(.W(PKW)) u_reg (
         .clk   (clk),
         .rst   (rst),
         .vld_i (stg_v[i]),
         .d_i   (stg_d[i]),
         .vld_q (stg_v[i+1]),
         .d_q   (stg_d[i+1])
      );
   end

   muladd_ctrl_t     dp_ctrl;
   logic [OPW-1:0]   dp_a, dp_b;
   logic [ACCW-1:0]  dp_c, dp_z;

   assign dp_a    = stg_d[NIN][A_LO +: OPW];
   assign dp_b    = stg_d[NIN][B_LO +: OPW];
   assign dp_c    = stg_d[NIN][C_LO +: ACCW];
   assign dp_ctrl = muladd_ctrl_t'(stg_d[NIN][K_LO +: CTRL_W]);

   muladd_core #(.OPW(OPW), .ACCW(ACCW)) u_core (
      .live (stg_v[NIN]),
      .ctrl (dp_ctrl),
      .a    (dp_a),
      .b    (dp_b),
      .c    (dp_c),
      .z    (dp_z)
   );

   muladd_reg #(.W(ACCW)) u_out (
      .clk   (clk),
      .rst   (rst),
      .vld_i (stg_v[NIN]),
      .d_i   (dp_z),
      .vld_q (out_valid),
      .d_q   (out_z)
   );

   AST_OUT_FROM_PIPE: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(stg_v[NIN])); // R5

endmodule

// File: tb/test_muladd_pipe.sv
module test_muladd_pipe;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_a = '0, in_b = '0;
   logic [15:0] in_c = '0;
   logic        in_tc = 1'b0, in_neg = 1'b0, in_ci = 1'b0;
   logic        out_valid;
   logic [15:0] out_z;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   int    q_exp [$];
   int    q_cyc [$];
   string q_tag [$];

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   muladd_pipe i_muladd_pipe (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .in_tc(in_tc), .in_neg(in_neg), .in_ci(in_ci),
      .out_valid(out_valid), .out_z(out_z)
   );

   function automatic int model(input logic [7:0] a, input logic [7:0] b,
                                input logic [15:0] c, input logic tc,
                                input logic neg, input logic ci);
      longint av, bv, cv, r;
      av = tc ? longint'($signed(a)) : longint'(a);
      bv = tc ? longint'($signed(b)) : longint'(b);
      cv = tc ? longint'($signed(c)) : longint'(c);
      av = av + longint'(ci);
      if (neg) av = -av;
      r = av * bv + cv;
      return int'(r & 64'hFFFF);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: one operand set per call, one cycle each
   task automatic drive(input string tag, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] c, input logic tc, input logic neg,
                        input logic ci);
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_c = c;
      in_tc = tc; in_neg = neg; in_ci = ci;
      q_exp.push_back(model(a, b, c, tc, neg, ci));
      q_cyc.push_back(cyc);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor: compares every result against the scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (!rst && out_valid) begin
            if (q_exp.size() == 0) begin
               check("R7 unexpected result", 1, 0);
            end else begin
               int    e, c0;
               string t;
               e  = q_exp.pop_front();
               c0 = q_cyc.pop_front();
               t  = q_tag.pop_front();
               check(t, int'(out_z), e);
               check({t, " R5 latency"}, cyc - c0, 4);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] corner [4];
      corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;

      // R9: idle after reset gives no result
      repeat (3) @(negedge clk);
      check("R9 valid in reset", int'(out_valid), 0);
      rst = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R9 valid idle", int'(out_valid), 0);
      end

      // R4 and R8 directed values
      drive("R4 increment 0xFF+1", 8'hFF, 8'h03, 16'h0000, 1'b0, 1'b0, 1'b1);
      drive("R8 negate -128",      8'h80, 8'h02, 16'h0000, 1'b1, 1'b1, 1'b0);
      drive("R1 plain unsigned",   8'hFF, 8'hFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
      drive("R2 plain signed",     8'hFF, 8'hFF, 16'hFFFF, 1'b1, 1'b0, 1'b0);
      idle(8);

      // corner sweep, back to back, controls changing every cycle (R6)
      for (int m = 0; m < 4; m++)
         for (int ia = 0; ia < 4; ia++)
            for (int ib = 0; ib < 4; ib++)
               for (int ci = 0; ci < 2; ci++) begin
                  logic tc, ng;
                  tc = logic'(m[0] ^ ci[0]);
                  ng = logic'(m[1] ^ ib[0]);
                  drive(ng ? "R3 corner negate" : (tc ? "R2 corner signed" : "R1 corner unsigned"),
                        corner[ia], corner[ib], (ia[0] ? 16'h8001 : 16'h1234),
                        tc, ng, logic'(ci[0]));
               end
      idle(8);

      // random traffic with bubbles (R5, R6)
      for (int k = 0; k < 300; k++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[31:29] == 3'd0) idle(1 + int'(r[28:27]));
         drive("R6 random", r[7:0], r[15:8], $urandom, r[16], r[17], r[18]);
      end
      idle(8);

      // R7: reset drops work in flight
      drive("R7 before reset", 8'h11, 8'h22, 16'h3333, 1'b0, 1'b0, 1'b0);
      drive("R7 before reset", 8'h44, 8'h55, 16'h6666, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      q_exp.delete(); q_cyc.delete(); q_tag.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R7 flushed", int'(out_valid), 0);
      end
      drive("R7 after reset", 8'h80, 8'h80, 16'h0001, 1'b1, 1'b0, 1'b1);
      idle(8);

      check("R5 scoreboard drained", q_exp.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule